// File: doc/BRIEF.md
# Single-Cell Battery Protection Controller

This block is the digital decision core of a one-cell battery pack protector. Analog comparators outside the block turn the cell voltage and the voltage of the pack's current-sense node into clean, clock-synchronous flags. The block turns those flags into three controls:

- an enable for the charge FET,
- an enable for the discharge FET,
- an enable for a pull-down resistor from the sense node to ground.

Every fault condition has to persist for its own detection window before it acts. A shorter glitch clears that condition's timer.

The machine has five states:

| State | Code |
|---|---|
| NORMAL | 0 |
| OVERCHARGED | 1 |
| OVERCURRENT | 2 |
| OVERDISCHARGED | 3 |
| ABNORMAL_CHARGE | 4 |

NORMAL has four exits:

- DETECT_CURRENT goes to OVERCURRENT. It fires on the first of three tiered current timers to expire: short, then level 2, then level 1.
- DETECT_LOW goes to OVERDISCHARGED.
- DETECT_HIGH goes to OVERCHARGED.
- DETECT_ABNORMAL goes to ABNORMAL_CHARGE.

Each fault state has its own release transition back to NORMAL:

- OVERCHARGED leaves by RELEASE_HYST, RELEASE_LOAD or RELEASE_UNPLUG.
- OVERCURRENT leaves by CLEAR_CURRENT.
- OVERDISCHARGED leaves by CLEAR_LOW.
- ABNORMAL_CHARGE leaves by CLEAR_ABNORMAL.

The outputs are registered. The encoded state is brought out so that it can be observed.

Top module: `cellguard_ctrl`

## Requirements
- R1: After reset, and in NORMAL, `state_code` is 0, `chg_en` is 1, `dis_en` is 1 and `pd_en` is 0. `state_code` never exceeds 4.
- R2: When `vbat_hi` is high at `D_OVC` consecutive rising edges in NORMAL, the state becomes OVERCHARGED (code 1) at the last of those edges. `chg_en` then drops to 0 while `dis_en` stays 1. One edge fewer leaves the state at 0.
- R3: In OVERCHARGED with no charger seen, `vbat_rel` high at an edge returns the state to 0 (RELEASE_HYST).
- R4: In OVERCHARGED with no charger seen, `vbat_hi` low together with `mon_oc1` high at an edge returns the state to 0 (RELEASE_LOAD).
- R5: Once `chg_det` is high in OVERCHARGED, the state holds at 1 while `chg_det` stays high, whatever `vbat_rel` does. The first edge with `chg_det` low returns the state to 0 (RELEASE_UNPLUG).
- R6: In NORMAL with `vbat_hi` low, each current flag has its own detection window:

  | Flag | Window | Ordering |
  |---|---|---|
  | `mon_short` | `D_SHORT` edges | shortest |
  | `mon_oc2` | `D_OC2` edges | between the other two |
  | `mon_oc1` | `D_OC1` edges | longest |

  When any of these windows completes, the state becomes OVERCURRENT (code 2), with `dis_en` 0, `chg_en` 1 and `pd_en` 1.
- R7: OVERCURRENT holds while `mon_oc1` is high. The first edge with `mon_oc1` low returns the state to 0 and clears `pd_en`.
- R8: While `vbat_hi` is high, the three current timers are held clear and OVERCURRENT cannot be entered.
- R9: When `abn_chg` is high for `D_OVC` consecutive edges in NORMAL, the state becomes ABNORMAL_CHARGE (code 4), with `chg_en` 0 and `dis_en` 1. It returns to 0 at the first edge with both `abn_chg` and `chg_det` low.
- R10: When `vbat_lo` is high for `D_OVD` consecutive edges in NORMAL, the state becomes OVERDISCHARGED (code 3), with `dis_en` 0 and `chg_en` 1. It returns to 0 at the first edge with `vbat_lo` low.
- R11: A flag that is low at any edge before its window completes restarts that window from zero.
- R12: If several windows complete at the same edge, the winner follows this order: current (code 2) first, then overdischarge (code 3), then overcharge (code 1), then abnormal charge (code 4). The outputs change at the same edge as the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vbat_hi | input | 1 | Cell above the overcharge threshold |
| vbat_rel | input | 1 | Cell below the overcharge release level |
| vbat_lo | input | 1 | Cell below the overdischarge threshold |
| mon_oc1 | input | 1 | Sense node at or above current level 1 |
| mon_oc2 | input | 1 | Sense node at or above current level 2 |
| mon_short | input | 1 | Sense node at or above the short-circuit level |
| chg_det | input | 1 | Sense node below the charger-detect level (charger present) |
| abn_chg | input | 1 | Sense node below the abnormal charge-current level |
| chg_en | output | 1 | Charge FET enable |
| dis_en | output | 1 | Discharge FET enable |
| pd_en | output | 1 | Sense-node pull-down enable |
| state_code | output | 3 | Encoded state (0 to 4 as in R1 to R12) |

## Verification
A detection is due at exactly the rising edge that completes its window: the D-th consecutive edge with the flag high. Every release is due at the first edge at which its condition holds. The outputs move at that same edge, because they are registered from the next state.

The bench changes inputs on falling edges and samples outputs on the following falling edge. Each directed check therefore falls a known whole number of edges after its stimulus. This includes the window-minus-one checks that must still read code 0.

A cycle model runs on the same rising edges during the seeded random phase. It is compared with the outputs at every falling edge.

// File: rtl/cellguard_pkg.sv
package cellguard_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL      = 3'd0,
        ST_OVERCHARGED = 3'd1,
        ST_OVERCURRENT = 3'd2,
        ST_OVERDISCH   = 3'd3,
        ST_ABNORMAL    = 3'd4
    } prot_state_e;

    // Timer slots; the order fixes which flag feeds which window.
    localparam int unsigned TMR_HIGH    = 0;
    localparam int unsigned TMR_LOW     = 1;
    localparam int unsigned TMR_OC1     = 2;
    localparam int unsigned TMR_OC2     = 3;
    localparam int unsigned TMR_SHORT   = 4;
    localparam int unsigned TMR_ABNORM  = 5;
    localparam int unsigned NUM_TMR     = 6;

    // Current-tier slots are contiguous so a range reduce covers them.
    localparam int unsigned CUR_FIRST   = TMR_OC1;
    localparam int unsigned CUR_LAST    = TMR_SHORT;

    function automatic int unsigned cnt_width(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/cellguard_timer.sv
module cellguard_timer
    import cellguard_pkg::*;
#(
    parameter int unsigned DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic flag,
    output logic fire
);
    localparam int unsigned CW = cnt_width(DELAY);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;
    logic          live;

    assign live = arm & flag;
    assign fire = live && (cnt_q == LAST);

    // Counts consecutive qualified edges; holds at LAST until the
    // owning state leaves NORMAL and arm drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!live) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cellguard_fsm.sv
module cellguard_fsm
    import cellguard_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] fire,
    input  logic               vbat_hi,
    input  logic               vbat_rel,
    input  logic               vbat_lo,
    input  logic               mon_oc1,
    input  logic               chg_det,
    input  logic               abn_chg,
    output prot_state_e        state_q,
    output logic               chg_en,
    output logic               dis_en,
    output logic               pd_en
);
    prot_state_e state_d;
    logic        seen_q;
    logic        seen_d;
    logic        cur_fire;

    assign cur_fire = |fire[CUR_LAST:CUR_FIRST];

    always_comb begin
        state_d = state_q;
        seen_d  = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                if (cur_fire)
                    state_d = ST_OVERCURRENT;          // DETECT_CURRENT
                else if (fire[TMR_LOW])
                    state_d = ST_OVERDISCH;            // DETECT_LOW
                else if (fire[TMR_HIGH])
                    state_d = ST_OVERCHARGED;          // DETECT_HIGH
                else if (fire[TMR_ABNORM])
                    state_d = ST_ABNORMAL;             // DETECT_ABNORMAL
            end
            ST_OVERCHARGED: begin
                if (chg_det) begin
                    seen_d = 1'b1;                     // charger blocks release
                end else if (seen_q) begin
                    state_d = ST_NORMAL;               // RELEASE_UNPLUG
                end else if (vbat_rel) begin
                    state_d = ST_NORMAL;               // RELEASE_HYST
                end else if (!vbat_hi && mon_oc1) begin
                    state_d = ST_NORMAL;               // RELEASE_LOAD
                end
            end
            ST_OVERCURRENT: begin
                if (!mon_oc1)
                    state_d = ST_NORMAL;               // CLEAR_CURRENT
            end
            ST_OVERDISCH: begin
                if (!vbat_lo)
                    state_d = ST_NORMAL;               // CLEAR_LOW
            end
            ST_ABNORMAL: begin
                if (!abn_chg && !chg_det)
                    state_d = ST_NORMAL;               // CLEAR_ABNORMAL
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            seen_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
        end
    end

    // Output register, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_en <= 1'b1;
            dis_en <= 1'b1;
            pd_en  <= 1'b0;
        end else begin
            chg_en <= !((state_d == ST_OVERCHARGED) || (state_d == ST_ABNORMAL));
            dis_en <= !((state_d == ST_OVERCURRENT) || (state_d == ST_OVERDISCH));
            pd_en  <= (state_d == ST_OVERCURRENT);
        end
    end

endmodule

// File: rtl/cellguard_ctrl.sv
module cellguard_ctrl
    import cellguard_pkg::*;
#(
    parameter int unsigned D_OVC   = 40,
    parameter int unsigned D_OVD   = 24,
    parameter int unsigned D_OC1   = 16,
    parameter int unsigned D_OC2   = 8,
    parameter int unsigned D_SHORT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vbat_hi,
    input  logic       vbat_rel,
    input  logic       vbat_lo,
    input  logic       mon_oc1,
    input  logic       mon_oc2,
    input  logic       mon_short,
    input  logic       chg_det,
    input  logic       abn_chg,
    output logic       chg_en,
    output logic       dis_en,
    output logic       pd_en,
    output logic [2:0] state_code
);
    // Abnormal charge shares the overcharge window.
    localparam int unsigned DLY [NUM_TMR] = '{D_OVC, D_OVD, D_OC1, D_OC2, D_SHORT, D_OVC};

    prot_state_e        state_q;
    logic [NUM_TMR-1:0] tmr_flag;
    logic [NUM_TMR-1:0] tmr_arm;
    logic [NUM_TMR-1:0] tmr_fire;
    logic               in_normal;

    assign in_normal = (state_q == ST_NORMAL);

    always_comb begin
        tmr_flag             = '0;
        tmr_flag[TMR_HIGH]   = vbat_hi;
        tmr_flag[TMR_LOW]    = vbat_lo;
        tmr_flag[TMR_OC1]    = mon_oc1;
        tmr_flag[TMR_OC2]    = mon_oc2;
        tmr_flag[TMR_SHORT]  = mon_short;
        tmr_flag[TMR_ABNORM] = abn_chg;
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        if (g >= CUR_FIRST && g <= CUR_LAST) begin : g_cur
            // Current tiers are held clear while the cell is above threshold.
            assign tmr_arm[g] = in_normal && !vbat_hi;
        end else begin : g_volt
            assign tmr_arm[g] = in_normal;
        end
        cellguard_timer #(.DELAY(DLY[g])) u_tmr (
            .clk  (clk),
            .rst_n(rst_n),
            .arm  (tmr_arm[g]),
            .flag (tmr_flag[g]),
            .fire (tmr_fire[g])
        );
    end

    cellguard_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (tmr_fire),
        .vbat_hi (vbat_hi),
        .vbat_rel(vbat_rel),
        .vbat_lo (vbat_lo),
        .mon_oc1 (mon_oc1),
        .chg_det (chg_det),
        .abn_chg (abn_chg),
        .state_q (state_q),
        .chg_en  (chg_en),
        .dis_en  (dis_en),
        .pd_en   (pd_en)
    );

    assign state_code = state_q;

endmodule

// File: rtl/cellguard_ctrl_chk.sv
module cellguard_ctrl_chk #(
    parameter int unsigned D_OVD = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       vbat_hi,
    input logic       vbat_lo,
    input logic       mon_oc1,
    input logic       chg_en,
    input logic       dis_en,
    input logic       pd_en,
    input logic [2:0] state_code
);
    int unsigned lo_run;

    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_run <= 0;
        else if (state_code == 3'd0 && vbat_lo)
            lo_run <= lo_run + 1;
        else
            lo_run <= 0;
    end

    // R1
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 3'd4);

    // R2
    ovc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1 && $past(state_code) == 3'd0) |-> $past(vbat_hi));

    // R2
    ovc_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1) |-> (!chg_en && dis_en));

    // R6
    pulldown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_en |-> (!dis_en && state_code == 3'd2));

    // R7
    oc_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_code) == 3'd2 && state_code != 3'd2) |-> !$past(mon_oc1));

    // R8
    oc_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2 && $past(state_code) == 3'd0) |-> !$past(vbat_hi));

    // R10
    ovd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3 && $past(state_code) == 3'd0) |-> $past(vbat_lo));

    // R11
    ovd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3 && $past(state_code) == 3'd0) |-> (lo_run >= D_OVD));

endmodule

bind cellguard_ctrl cellguard_ctrl_chk #(.D_OVD(D_OVD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vbat_hi   (vbat_hi),
    .vbat_lo   (vbat_lo),
    .mon_oc1   (mon_oc1),
    .chg_en    (chg_en),
    .dis_en    (dis_en),
    .pd_en     (pd_en),
    .state_code(state_code)
);

// File: tb/cellguard_ctrl_test.sv
module cellguard_ctrl_test;
    localparam int TCK     = 10;
    localparam int P_OVC   = 12;
    localparam int P_OVD   = 10;
    localparam int P_OC1   = 10;
    localparam int P_OC2   = 5;
    localparam int P_SHORT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 0, rel = 0, lo = 0, oc1 = 0, oc2 = 0, sh = 0, chg = 0, abn = 0;
    logic chg_en, dis_en, pd_en;
    logic [2:0] code;

    int n_chk = 0, n_err = 0;
    bit done = 0, model_on = 0;

    always #(TCK/2) clk = ~clk;

    cellguard_ctrl #(.D_OVC(P_OVC), .D_OVD(P_OVD), .D_OC1(P_OC1),
                     .D_OC2(P_OC2), .D_SHORT(P_SHORT)) uut (
        .clk(clk), .rst_n(rst_n), .vbat_hi(hi), .vbat_rel(rel), .vbat_lo(lo),
        .mon_oc1(oc1), .mon_oc2(oc2), .mon_short(sh), .chg_det(chg),
        .abn_chg(abn), .chg_en(chg_en), .dis_en(dis_en), .pd_en(pd_en),
        .state_code(code));

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected outputs for a given state code
    function automatic int exp_chg(input int s); return (s == 1 || s == 4) ? 0 : 1; endfunction
    function automatic int exp_dis(input int s); return (s == 2 || s == 3) ? 0 : 1; endfunction
    function automatic int exp_pd (input int s); return (s == 2) ? 1 : 0; endfunction

    task automatic expect_state(input string tag, input int s);
        check({tag, " state"}, int'(code), s);
        check({tag, " chg_en"}, int'(chg_en), exp_chg(s));
        check({tag, " dis_en"}, int'(dis_en), exp_dis(s));
        check({tag, " pd_en"}, int'(pd_en), exp_pd(s));
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags();
        {hi, rel, lo, oc1, oc2, sh, chg, abn} = '0;
    endtask

    task automatic enter_ovc();
        clear_flags(); hi = 1; hold(P_OVC);
    endtask

    task automatic back_to_normal();
        clear_flags(); rel = 1; hold(1); clear_flags(); hold(2);
    endtask

    // ---------------- cycle model ----------------
    int m_st = 0;
    bit m_seen = 0;
    int m_cnt [6];

    always @(posedge clk) begin
        int d [6];
        bit f [6];
        int nc [6];
        bit fr [6];
        int ns;
        bit nseen;
        d = '{P_OVC, P_OVD, P_OC1, P_OC2, P_SHORT, P_OVC};
        f = '{hi, lo, oc1 && !hi, oc2 && !hi, sh && !hi, abn};
        ns = m_st;
        nseen = 0;
        if (!rst_n) begin
            ns = 0;
            foreach (nc[i]) nc[i] = 0;
        end else begin
            foreach (nc[i]) begin
                nc[i] = (m_st == 0 && f[i]) ? m_cnt[i] + 1 : 0;
                fr[i] = nc[i] >= d[i];
            end
            case (m_st)
                0: if (fr[2] || fr[3] || fr[4]) ns = 2;
                   else if (fr[1]) ns = 3;
                   else if (fr[0]) ns = 1;
                   else if (fr[5]) ns = 4;
                1: if (chg) nseen = 1;
                   else if (m_seen) ns = 0;
                   else if (rel || (!hi && oc1)) ns = 0;
                2: if (!oc1) ns = 0;
                3: if (!lo) ns = 0;
                default: if (!abn && !chg) ns = 0;
            endcase
            if (ns != 0) foreach (nc[i]) nc[i] = 0;
        end
        m_st   <= ns;
        m_seen <= nseen;
        m_cnt  <= nc;
    end

    always @(negedge clk) begin
        if (model_on) expect_state("R12 model", m_st);
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd2024));
        hold(3);
        rst_n = 1;
        hold(1);
        expect_state("R1 reset", 0);

        // R2 window edge
        hi = 1; hold(P_OVC - 1);
        expect_state("R2 one short", 0);
        hold(1);
        expect_state("R2 entered", 1);

        // R3 hysteresis release
        hi = 0; rel = 1; hold(1);
        expect_state("R3 release", 0);

        // R4 load release
        enter_ovc();
        hi = 0; oc1 = 1; hold(1);
        expect_state("R4 load release", 0);
        oc1 = 0; hold(2);

        // R5 charger latch
        enter_ovc();
        hi = 0; chg = 1; hold(1); rel = 1; hold(3);
        expect_state("R5 blocked", 1);
        chg = 0; rel = 0; hold(1);
        expect_state("R5 unplug", 0);
        hold(2);

        // R6 short tier
        sh = 1; oc2 = 1; oc1 = 1; hold(P_SHORT - 1);
        expect_state("R6 short early", 0);
        hold(1);
        expect_state("R6 short", 2);
        // R7 hold then exit
        sh = 0; oc2 = 0; hold(3);
        expect_state("R7 hold", 2);
        oc1 = 0; hold(1);
        expect_state("R7 exit", 0);
        // R6 level 2 tier
        oc2 = 1; oc1 = 1; hold(P_OC2 - 1);
        expect_state("R6 oc2 early", 0);
        hold(1);
        expect_state("R6 oc2", 2);
        clear_flags(); hold(2);
        // R6 level 1 tier
        oc1 = 1; hold(P_OC1 - 1);
        expect_state("R6 oc1 early", 0);
        hold(1);
        expect_state("R6 oc1", 2);
        clear_flags(); hold(2);

        // R8 suppression while high
        hi = 1; oc1 = 1; oc2 = 1; sh = 1; hold(P_OVC - 1);
        expect_state("R8 suppressed", 0);
        hold(1);
        expect_state("R8 overcharge wins", 1);
        back_to_normal();

        // R9 abnormal charge
        abn = 1; chg = 1; hold(P_OVC - 1);
        expect_state("R9 early", 0);
        hold(1);
        expect_state("R9 entered", 4);
        abn = 0; hold(1);
        expect_state("R9 charger holds", 4);
        chg = 0; hold(1);
        expect_state("R9 release", 0);

        // R10 overdischarge
        lo = 1; hold(P_OVD);
        expect_state("R10 entered", 3);
        lo = 0; hold(1);
        expect_state("R10 release", 0);

        // R11 glitch restarts window
        lo = 1; hold(P_OVD - 1); lo = 0; hold(1); lo = 1; hold(P_OVD - 1);
        expect_state("R11 restarted", 0);
        hold(1);
        expect_state("R11 entered", 3);
        clear_flags(); hold(2);

        // R12 same-edge priority: current beats overdischarge
        lo = 1; oc1 = 1; hold(P_OC1);
        expect_state("R12 priority", 2);
        clear_flags(); hold(3);

        // R12 random phase against cycle model
        model_on = 1;
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(19) == 0) hi  = ~hi;
            if ($urandom_range(9)  == 0) rel = ~rel;
            if ($urandom_range(19) == 0) lo  = ~lo;
            if ($urandom_range(11) == 0) oc1 = ~oc1;
            if ($urandom_range(15) == 0) oc2 = ~oc2;
            if ($urandom_range(23) == 0) sh  = ~sh;
            if ($urandom_range(13) == 0) chg = ~chg;
            if ($urandom_range(21) == 0) abn = ~abn;
            hold(1);
        end
        model_on = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(TCK * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule